// File: doc/BRIEF.md
# Multi-Function Port Pin Cell

This block controls one bidirectional pin of a small microcontroller port. Three storage bits are loaded from the internal register bus: the output data value, the direction (1 = input, 0 = drive) and a pull-up request. Two further bits are loaded the same way: an analog-select bit and a change-detect enable. When analog-select is set, the digital input path is cut off, so register reads and the routed digital input both give 0. A clock-output override replaces the data bit with the instruction-rate clock (oscillator divided by four) and turns the driver on. The analog converter, the comparator, the timer gate and the oscillator sit outside the cell and only use the signals it routes to them.

The pin level passes through a two-flop synchronizer before it is used. Every port read strobe copies the synchronized level into a snapshot bit. If change detection is enabled and the live synchronized level differs from the snapshot, a shared sticky flag is set. Change events from the other pins of the port also set this flag. A small state machine holds the flag in one of two states, `CHG_IDLE` and `CHG_PENDING`. The move `CHG_IDLE -> CHG_PENDING` (SET) happens on a local mismatch or on an external change event. The move `CHG_PENDING -> CHG_IDLE` (CLEAR) happens when software writes 0 to the flag and no set event occurs in the same cycle, because set wins. In every other case the state holds: HOLD_IDLE or HOLD_PENDING.

Top module: `gpio_pin_cell`

## Requirements
- R1: After reset the pin is an input (`pin_oe`=0), analog-select is 1 (so `rd_data`=0), the pull-up is off, change detection is disabled and `chg_flag`=0.
- R2: A write strobe on `wr_data` or `wr_dir` loads `wr_bit` at the clock edge. `pin_out` shows the data bit when the clock override is off. `pin_oe` is the inverse of the direction bit.
- R3: While `clkout_en`=1, `pin_out` equals `fosc4` and `pin_oe`=1, whatever the data and direction bits hold.
- R4: While the analog-select bit is 1, `rd_data`=0 and `pin_din`=0 for any pin level.
- R5: `pull_on` is 1 only when all of these hold: the pull-up bit is 1, `pull_glob_n`=0, the direction bit is 1, analog-select is 0 and `clkout_en`=0.
- R6: `rd_data` reports the pin level, not the data bit. A new pin level appears there after exactly two rising clock edges.
- R7: With change detection enabled, the flag sets one edge after the synchronized level differs from the snapshot taken at the last `rd_port` strobe.
- R8: With change detection disabled, pin changes never set the flag.
- R9: `chg_other`=1 at a clock edge sets the flag.
- R10: The flag is sticky. Writing 0 through `wr_chg_flag` clears it. Writing 1 has no effect. A set event in the same cycle as a clear write leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_bit | input | 1 | Bus bit written by any write strobe |
| wr_data | input | 1 | Write strobe, output data bit |
| wr_dir | input | 1 | Write strobe, direction bit (1 = input) |
| wr_pull | input | 1 | Write strobe, pull-up request bit |
| wr_ana | input | 1 | Write strobe, analog-select bit |
| wr_chg_en | input | 1 | Write strobe, change-detect enable |
| wr_chg_flag | input | 1 | Write strobe, change flag (0 clears) |
| rd_port | input | 1 | Port read strobe, takes the snapshot |
| rd_data | output | 1 | Pin level seen by a port read |
| clkout_en | input | 1 | Clock-output override |
| fosc4 | input | 1 | Instruction-rate clock for the override |
| pull_glob_n | input | 1 | Global pull-up enable, active low |
| pin_in | input | 1 | Raw pin level |
| pin_out | output | 1 | Pin driver value |
| pin_oe | output | 1 | Pin driver enable |
| pull_on | output | 1 | Weak pull-up enable |
| pin_din | output | 1 | Gated digital input for timer gate and other users |
| chg_other | input | 1 | Change event from the other port pins |
| chg_flag | output | 1 | Shared change interrupt flag |

## Verification
If the flag state machine is in the wrong state, the fault shows on `chg_flag` in the same cycle, and a missed set or missed clear shows one edge after the triggering event. If the snapshot bit is wrong, the flag rises three edges after an unrelated pin change, or stays low when it should have risen. A wrong synchronizer depth moves the `rd_data` edge off the second clock. A wrong configuration bit shows at once on `pin_oe`, `pull_on` or `rd_data`, so the bench samples each of these one cycle after every write.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
    typedef enum logic {
        CHG_IDLE    = 1'b0,
        CHG_PENDING = 1'b1
    } chg_state_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs #(
    parameter logic RST_DIR = 1'b1,
    parameter logic RST_ANA = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_bit,
    input  logic wr_data,
    input  logic wr_dir,
    input  logic wr_pull,
    input  logic wr_ana,
    input  logic wr_chg_en,
    output logic data_q,
    output logic dir_q,
    output logic pull_q,
    output logic ana_q,
    output logic chg_en_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= 1'b0;
            dir_q    <= RST_DIR;
            pull_q   <= 1'b0;
            ana_q    <= RST_ANA;
            chg_en_q <= 1'b0;
        end else begin
            if (wr_data)   data_q   <= wr_bit;
            if (wr_dir)    dir_q    <= wr_bit;
            if (wr_pull)   pull_q   <= wr_bit;
            if (wr_ana)    ana_q    <= wr_bit;
            if (wr_chg_en) chg_en_q <= wr_bit;
        end
    end
endmodule

// File: rtl/pin_chg_fsm.sv
module pin_chg_fsm
    import gpio_pin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic snap_take,
    input  logic enable,
    input  logic other_evt,
    input  logic clr_wr,
    input  logic clr_bit,
    output logic hit,
    output logic flag
);
    chg_state_t state, state_nx;
    logic       snap_q;
    logic       set_evt;
    logic       clr_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         snap_q <= 1'b0;
        else if (snap_take) snap_q <= level;
    end

    assign hit     = enable & (level ^ snap_q);
    assign set_evt = hit | other_evt;
    assign clr_evt = clr_wr & ~clr_bit;

    always_comb begin
        state_nx = state;
        unique case (state)
            CHG_IDLE:    if (set_evt) state_nx = CHG_PENDING;
            CHG_PENDING: if (clr_evt && !set_evt) state_nx = CHG_IDLE;
            default:     state_nx = CHG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CHG_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        flag = (state == CHG_PENDING);
    end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell #(
    parameter int   SYNC_STAGES = 2,
    parameter logic RST_DIR     = 1'b1,
    parameter logic RST_ANA     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_bit,
    input  logic wr_data,
    input  logic wr_dir,
    input  logic wr_pull,
    input  logic wr_ana,
    input  logic wr_chg_en,
    input  logic wr_chg_flag,
    input  logic rd_port,
    output logic rd_data,
    input  logic clkout_en,
    input  logic fosc4,
    input  logic pull_glob_n,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic pull_on,
    output logic pin_din,
    input  logic chg_other,
    output logic chg_flag
);
    logic data_q, dir_q, pull_q, ana_q, chg_en_q;
    logic pin_sync_q;
    logic chg_hit;

    pin_cfg_regs #(.RST_DIR(RST_DIR), .RST_ANA(RST_ANA)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_bit   (wr_bit),
        .wr_data  (wr_data),
        .wr_dir   (wr_dir),
        .wr_pull  (wr_pull),
        .wr_ana   (wr_ana),
        .wr_chg_en(wr_chg_en),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .pull_q   (pull_q),
        .ana_q    (ana_q),
        .chg_en_q (chg_en_q)
    );

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (pin_sync_q)
    );

    // Digital input path, cut off in analog mode
    assign pin_din = pin_sync_q & ~ana_q;
    assign rd_data = pin_din;

    // Driver: 2:1 select between data bit and instruction clock
    assign pin_out = clkout_en ? fosc4 : data_q;
    assign pin_oe  = clkout_en | ~dir_q;

    // Pull-up only on an undriven digital input
    assign pull_on = pull_q & ~pull_glob_n & dir_q & ~ana_q & ~clkout_en;

    pin_chg_fsm u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pin_din),
        .snap_take(rd_port),
        .enable   (chg_en_q),
        .other_evt(chg_other),
        .clr_wr   (wr_chg_flag),
        .clr_bit  (wr_bit),
        .hit      (chg_hit),
        .flag     (chg_flag)
    );
endmodule

// File: rtl/gpio_pin_cell_chk.sv
module gpio_pin_cell_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_bit,
    input logic wr_data,
    input logic wr_chg_flag,
    input logic clkout_en,
    input logic pin_out,
    input logic pin_oe,
    input logic pull_on,
    input logic rd_data,
    input logic pin_din,
    input logic chg_other,
    input logic chg_flag,
    input logic ana_q,
    input logic chg_en_q,
    input logic chg_hit
);
    AST_DATA_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && !clkout_en |=> (clkout_en || pin_out == $past(wr_bit))); // R2
    AST_CLKOUT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        clkout_en |-> pin_oe); // R3
    AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ana_q |-> (!rd_data && !pin_din)); // R4
    AST_PULL_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> !pull_on); // R5
    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_flag && !chg_en_q && !chg_other |=> !chg_flag); // R8
    AST_OTHER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        chg_other |=> chg_flag); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        chg_flag && !(wr_chg_flag && !wr_bit) |=> chg_flag); // R10
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        chg_flag && wr_chg_flag && !wr_bit && !chg_other && !chg_hit |=> !chg_flag); // R10
endmodule

bind gpio_pin_cell gpio_pin_cell_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_bit     (wr_bit),
    .wr_data    (wr_data),
    .wr_chg_flag(wr_chg_flag),
    .clkout_en  (clkout_en),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .pull_on    (pull_on),
    .rd_data    (rd_data),
    .pin_din    (pin_din),
    .chg_other  (chg_other),
    .chg_flag   (chg_flag),
    .ana_q      (ana_q),
    .chg_en_q   (chg_en_q),
    .chg_hit    (chg_hit)
);

// File: tb/gpio_pin_cell_tb.sv
module gpio_pin_cell_tb;
    localparam int SEL_OUT  = 0;
    localparam int SEL_OE   = 1;
    localparam int SEL_PULL = 2;
    localparam int SEL_RD   = 3;
    localparam int SEL_DIN  = 4;
    localparam int SEL_FLAG = 5;

    typedef struct {
        string tag;
        int    sel;
        logic  exp;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_bit = 1'b0, wr_data = 1'b0, wr_dir = 1'b0, wr_pull = 1'b0;
    logic wr_ana = 1'b0, wr_chg_en = 1'b0, wr_chg_flag = 1'b0, rd_port = 1'b0;
    logic clkout_en = 1'b0, fosc4 = 1'b0, pull_glob_n = 1'b0, pin_in = 1'b1;
    logic chg_other = 1'b0;
    logic rd_data, pin_out, pin_oe, pull_on, pin_din, chg_flag;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    gpio_pin_cell u_dut (
        .clk(clk), .rst_n(rst_n), .wr_bit(wr_bit), .wr_data(wr_data),
        .wr_dir(wr_dir), .wr_pull(wr_pull), .wr_ana(wr_ana),
        .wr_chg_en(wr_chg_en), .wr_chg_flag(wr_chg_flag), .rd_port(rd_port),
        .rd_data(rd_data), .clkout_en(clkout_en), .fosc4(fosc4),
        .pull_glob_n(pull_glob_n), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pull_on(pull_on), .pin_din(pin_din),
        .chg_other(chg_other), .chg_flag(chg_flag)
    );

    // Monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin : mon
        item_t it;
        logic  got;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.sel)
                SEL_OUT:  got = pin_out;
                SEL_OE:   got = pin_oe;
                SEL_PULL: got = pull_on;
                SEL_RD:   got = rd_data;
                SEL_DIN:  got = pin_din;
                default:  got = chg_flag;
            endcase
            n_checks++;
            if (got !== it.exp) begin
                n_errors++;
                $display("FAIL %s: got=%b expected=%b", it.tag, got, it.exp);
            end
        end
    end

    task automatic expect_val(input string tag, input int sel, input logic exp);
        item_t it;
        it.tag = tag;
        it.sel = sel;
        it.exp = exp;
        sb_q.push_back(it);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    // kind: 0 data, 1 dir, 2 pull, 3 ana, 4 chg_en, 5 flag
    task automatic bus_write(input int kind, input logic b);
        wr_bit = b;
        case (kind)
            0: wr_data = 1'b1;
            1: wr_dir = 1'b1;
            2: wr_pull = 1'b1;
            3: wr_ana = 1'b1;
            4: wr_chg_en = 1'b1;
            default: wr_chg_flag = 1'b1;
        endcase
        step(1);
        {wr_data, wr_dir, wr_pull, wr_ana, wr_chg_en, wr_chg_flag} = '0;
    endtask

    task automatic port_read();
        rd_port = 1'b1;
        step(1);
        rd_port = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        expect_val("R1 pin_oe", SEL_OE, 1'b0);
        expect_val("R1 rd_data analog", SEL_RD, 1'b0);
        expect_val("R1 pull off", SEL_PULL, 1'b0);
        expect_val("R1 flag", SEL_FLAG, 1'b0);

        // R6 read path and two-edge delay
        bus_write(3, 1'b0);
        expect_val("R6 rd high", SEL_RD, 1'b1);
        pin_in = 1'b0;
        step(1);
        expect_val("R6 one edge old", SEL_RD, 1'b1);
        step(1);
        expect_val("R6 two edges new", SEL_RD, 1'b0);

        // R5 pull-up qualifiers
        bus_write(2, 1'b1);
        expect_val("R5 pull on", SEL_PULL, 1'b1);
        pull_glob_n = 1'b1;
        step(1);
        expect_val("R5 global off", SEL_PULL, 1'b0);
        pull_glob_n = 1'b0;
        clkout_en = 1'b1;
        step(1);
        expect_val("R5 clkout off", SEL_PULL, 1'b0);
        clkout_en = 1'b0;
        step(1);
        expect_val("R5 back on", SEL_PULL, 1'b1);

        // R2 direction and data latch
        bus_write(1, 1'b0);
        expect_val("R2 oe on", SEL_OE, 1'b1);
        expect_val("R5 driven off", SEL_PULL, 1'b0);
        bus_write(0, 1'b1);
        expect_val("R2 out 1", SEL_OUT, 1'b1);
        expect_val("R6 rd is pin not latch", SEL_RD, 1'b0);
        bus_write(0, 1'b0);
        expect_val("R2 out 0", SEL_OUT, 1'b0);

        // R3 clock override
        bus_write(1, 1'b1);
        expect_val("R2 oe off", SEL_OE, 1'b0);
        clkout_en = 1'b1;
        fosc4 = 1'b1;
        step(1);
        expect_val("R3 out fosc4 high", SEL_OUT, 1'b1);
        expect_val("R3 oe forced", SEL_OE, 1'b1);
        fosc4 = 1'b0;
        bus_write(0, 1'b1);
        expect_val("R3 out fosc4 low", SEL_OUT, 1'b0);
        clkout_en = 1'b0;
        step(1);
        expect_val("R3 released", SEL_OUT, 1'b1);

        // R4 analog mode
        bus_write(3, 1'b1);
        pin_in = 1'b1;
        step(3);
        expect_val("R4 rd zero", SEL_RD, 1'b0);
        expect_val("R4 din zero", SEL_DIN, 1'b0);
        expect_val("R4 pull off", SEL_PULL, 1'b0);
        bus_write(3, 1'b0);
        expect_val("R4 left analog", SEL_DIN, 1'b1);

        // R8 change detect disabled
        port_read();
        pin_in = 1'b0;
        step(4);
        expect_val("R8 no flag", SEL_FLAG, 1'b0);
        pin_in = 1'b1;
        step(3);
        port_read();

        // R7 mismatch sets flag
        bus_write(4, 1'b1);
        step(2);
        expect_val("R7 match no flag", SEL_FLAG, 1'b0);
        pin_in = 1'b0;
        step(2);
        expect_val("R7 not yet", SEL_FLAG, 1'b0);
        step(1);
        expect_val("R7 flag set", SEL_FLAG, 1'b1);
        port_read();
        bus_write(5, 1'b0);
        expect_val("R10 cleared", SEL_FLAG, 1'b0);

        // R9 external events
        chg_other = 1'b1;
        step(1);
        chg_other = 1'b0;
        expect_val("R9 other sets", SEL_FLAG, 1'b1);

        // R10 write 1 ignored, set priority
        bus_write(5, 1'b1);
        expect_val("R10 write1 ignored", SEL_FLAG, 1'b1);
        chg_other = 1'b1;
        bus_write(5, 1'b0);
        chg_other = 1'b0;
        expect_val("R10 set wins", SEL_FLAG, 1'b1);
        bus_write(5, 1'b0);
        expect_val("R10 clear", SEL_FLAG, 1'b0);
        step(2);
        expect_val("R10 stays clear", SEL_FLAG, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule